// File: doc/BRIEF.md
# Periodic Wake-Up Interval Timer

This block counts 32.768 kHz ticks and raises an interrupt each time a programmed number of ticks has elapsed. The count advances once for every one-cycle tick enable. It returns to zero when it reaches the programmed period, and at that moment it sets a sticky interrupt flag. An interval lasts period/32768 seconds, so the resolution is about 30.5 µs and the longest interval is about 36.4 hours. Software reaches the block through a small byte-wide register file. That file holds four read-only count bytes, four read/write period bytes and one status byte.

Multi-byte values pass through one staging register that reads and writes share. A read of the lowest count byte snapshots the whole count into the staging register. The three upper count bytes are then read from that snapshot. This keeps the value intact when a carry occurs between byte reads. Period bytes are written from the top byte down into the staging register. Writing the lowest period byte commits all four bytes at once and restarts the count from zero. A guard state machine then blocks staged accesses until the next tick.

The guard state machine has two states. In `G_IDLE` staged accesses are served. A committing write moves it to `G_GUARD` (transition *commit*). `G_GUARD` returns to `G_IDLE` once the programmed number of ticks has arrived (transition *guard_done*). The period register survives the warm reset. Only power-on reset clears it.

Top module: `pit_timer`

## Requirements
- R1: After power-on reset, `irq` is 0, `rdata` is 0, every period byte reads 0 and the count stays 0 whatever ticks arrive.
- R2: While the period is nonzero, the count rises by exactly one on each cycle with `tick` high and holds otherwise.
- R3: On a tick where count+1 equals the period, the count becomes 0 and `irq` is set. With period P, the interrupt first appears on the P-th tick after the commit.
- R4: The interrupt stays set until a write to address 8 with data bit 0 set. A write with bit 0 clear has no effect. A set in the same cycle as a clear wins. The count keeps running while the flag is set.
- R5: Every read returns its byte in `rdata` one cycle after `rd`. A read of address 0 returns the live count bits 7:0 and snapshots all 32 count bits into the staging register. Reads of addresses 1, 2 and 3 return count bits 15:8, 23:16 and 31:24 from that snapshot.
- R6: Writes to addresses 7, 6 and 5 place period bits 31:24, 23:16 and 15:8 into the staging register and leave the active period unchanged. A write to address 4 loads {staged bytes, data} as the active period and clears the count.
- R7: Reads of addresses 4 to 7 return active period bits 7:0, 15:8, 23:16 and 31:24. These reads are served even while busy.
- R8: After a commit, status bit 1 (busy) reads 1 until the first tick that follows the commit. While busy, writes to addresses 4 to 7 and reads of addresses 0 to 3 are ignored: the period, count and staging register do not change, and `rdata` keeps its previous value.
- R9: The status byte at address 8 reads {6'b0, busy, irq}.
- R10: Warm reset clears the count, the interrupt, the staging register and busy, and keeps the period, so counting resumes. Power-on reset also clears the period.
- R11: A period of 0 keeps the count at 0 and never sets the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| warm_n | input | 1 | Warm reset, active low, asynchronous; keeps the period |
| tick | input | 1 | Synchronized one-cycle 32.768 kHz enable |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Sticky interval interrupt |

## Verification
A count that strays from the tick model shows up at the next four-byte read. The wrap misfires on the very tick that should set `irq`, and `irq` is visible at the port one cycle later. A stale or torn staging register shows up as a wrong upper byte. The bench provokes this by forcing a carry between the snapshot read and the upper-byte read. A stuck or missing guard state shows up as a wrong busy bit in the status byte, or as a served access that should have been dropped, within the few cycles after a commit.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef enum logic [0:0] {
        G_IDLE  = 1'b0,
        G_GUARD = 1'b1
    } guard_e;
endpackage

// File: rtl/pit_core.sv
module pit_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             irq_clr,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_inc;
    logic             run;
    logic             wrap;

    always_comb begin
        cnt_inc = cnt + CNT_W'(1);
        run     = tick && !restart && (period != '0);
        wrap    = run && (cnt_inc == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || wrap) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (wrap) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int NBYTES      = 4,
    parameter int ADDR_W      = 4,
    parameter int GUARD_TICKS = 1
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [8*NBYTES-1:0]   cnt,
    input  logic                  irq,
    output logic [7:0]            rdata,
    output logic [8*NBYTES-1:0]   period,
    output logic                  restart,
    output logic                  irq_clr,
    output logic                  busy
);
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int GC_W  = $clog2(GUARD_TICKS + 1);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(NBYTES);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * NBYTES);
    localparam logic [GC_W-1:0]   GC_END = GC_W'(GUARD_TICKS - 1);

    guard_e state_q, state_d;
    logic [GC_W-1:0]              gcnt_q;
    logic [NBYTES-1:0][7:0]       shadow_q;
    logic [NBYTES-1:0][7:0]       per_q;
    logic [NBYTES-1:0][7:0]       cnt_b;
    logic [IDX_W-1:0]             idx;
    logic is_cnt, is_per, is_stat;
    logic snap, stage_wr, commit, guard_done;

    assign cnt_b  = cnt;
    assign period = per_q;

    always_comb begin
        idx        = addr[IDX_W-1:0];
        is_cnt     = addr < A_PER;
        is_per     = (addr >= A_PER) && (addr < A_STAT);
        is_stat    = addr == A_STAT;
        snap       = rd && is_cnt && (idx == '0) && !busy;
        stage_wr   = wr && is_per && (idx != '0) && !busy;
        commit     = wr && is_per && (idx == '0) && !busy;
        guard_done = tick && (gcnt_q == GC_END);
        restart    = commit;
        irq_clr    = wr && is_stat && wdata[0];
    end

    // guard state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= G_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // guard next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_IDLE:  if (commit)     state_d = G_GUARD;
            G_GUARD: if (guard_done) state_d = G_IDLE;
            default: state_d = G_IDLE;
        endcase
    end

    // guard outputs
    always_comb begin
        busy = 1'b0;
        unique case (state_q)
            G_IDLE:  busy = 1'b0;
            G_GUARD: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcnt_q <= '0;
        end else if (commit) begin
            gcnt_q <= '0;
        end else if (busy && tick) begin
            gcnt_q <= gcnt_q + GC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (snap) begin
            shadow_q <= cnt_b;
        end else if (stage_wr) begin
            shadow_q[idx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            per_q <= '0;
        end else if (commit) begin
            per_q    <= shadow_q;
            per_q[0] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            if (is_cnt) begin
                if (!busy) rdata <= (idx == '0) ? cnt_b[0] : shadow_q[idx];
            end else if (is_per) begin
                rdata <= per_q[idx];
            end else if (is_stat) begin
                rdata <= {6'b0, busy, irq};
            end else begin
                rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
    parameter int NBYTES      = 4,
    parameter int ADDR_W      = 4,
    parameter int GUARD_TICKS = 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam int CNT_W = 8 * NBYTES;

    logic             rst_n;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;
    logic             restart;
    logic             irq_clr;
    logic             busy;

    assign rst_n = por_n & warm_n;

    pit_regs #(
        .NBYTES(NBYTES), .ADDR_W(ADDR_W), .GUARD_TICKS(GUARD_TICKS)
    ) u_regs (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
        .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .cnt(cnt_q), .irq(irq), .rdata(rdata), .period(period_q),
        .restart(restart), .irq_clr(irq_clr), .busy(busy)
    );

    pit_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .irq_clr(irq_clr), .period(period_q), .cnt(cnt_q), .irq(irq)
    );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int NBYTES = 4,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                por_n,
    input logic                warm_n,
    input logic                tick,
    input logic [ADDR_W-1:0]   addr,
    input logic [7:0]          wdata,
    input logic                wr,
    input logic                rd,
    input logic [7:0]          rdata,
    input logic                irq,
    input logic [8*NBYTES-1:0] cnt,
    input logic [8*NBYTES-1:0] period,
    input logic                busy
);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(NBYTES);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * NBYTES);

    logic run_n, commit, clr, busy_cnt_rd, per_wr;
    assign run_n       = por_n && warm_n;
    assign commit      = wr && (addr == A_PER) && !busy;
    assign clr         = wr && (addr == A_STAT) && wdata[0];
    assign busy_cnt_rd = busy && rd && (addr < A_PER);
    assign per_wr      = wr && (addr == A_PER);

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!run_n)
        (!tick && !commit) |=> $stable(cnt));

    p_below_period_r3: assert property (@(posedge clk) disable iff (!run_n)
        (period != '0) |-> (cnt < period));

    p_wrap_sets_irq_r3: assert property (@(posedge clk) disable iff (!run_n)
        (tick && !commit && (period != '0) && (cnt == period - 1'b1))
        |=> (irq && (cnt == '0)));

    p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!run_n)
        (irq && !clr) |=> irq);

    p_period_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
        !per_wr |=> $stable(period));

    p_busy_read_ignored_r8: assert property (@(posedge clk) disable iff (!run_n)
        busy_cnt_rd |=> $stable(rdata));

    p_stopped_r11: assert property (@(posedge clk) disable iff (!run_n)
        (period == '0) |-> (cnt == '0));
endmodule

bind pit_timer pit_timer_chk #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .tick(tick), .addr(addr),
    .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .irq(irq),
    .cnt(cnt_q), .period(period_q), .busy(busy)
);

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       warm_n = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pit_timer u0 (
        .clk(clk), .por_n(por_n), .warm_n(warm_n), .tick(tick), .addr(addr),
        .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic rd_cnt(output logic [31:0] v);
        logic [7:0] b;
        rd_reg(4'd0, b); v[7:0]   = b;
        rd_reg(4'd1, b); v[15:8]  = b;
        rd_reg(4'd2, b); v[23:16] = b;
        rd_reg(4'd3, b); v[31:24] = b;
    endtask

    task automatic set_period(input logic [31:0] p);
        wr_reg(4'd7, p[31:24]);
        wr_reg(4'd6, p[23:16]);
        wr_reg(4'd5, p[15:8]);
        wr_reg(4'd4, p[7:0]);
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 rdata", {24'b0, rdata}, 32'd0);
        for (int a = 4; a < 8; a++) begin
            rd_reg(4'(a), b);
            check("R1 period byte", {24'b0, b}, 32'd0);
        end
        do_tick(3);
        rd_cnt(v);
        check("R1 disabled count", v, 32'd0);

        // R2 R3 sweep over small periods
        for (int p = 1; p <= 6; p++) begin
            wr_reg(4'd8, 8'h01);
            set_period(32'(p));
            for (int t = 1; t <= 2 * p + 1; t++) begin
                do_tick(1);
                check("R3 irq port", {31'b0, irq}, (t >= p) ? 32'd1 : 32'd0);
                rd_cnt(v);
                check("R2 count", v, 32'(t % p));
                rd_reg(4'd8, b);
                check("R9 status", {24'b0, b}, (t >= p) ? 32'd1 : 32'd0);
            end
        end

        // R5 snapshot coherence across a carry
        wr_reg(4'd8, 8'h01);
        set_period(32'hFFFF_FFFF);
        do_tick(255);
        rd_reg(4'd0, b);
        check("R5 live lsb", {24'b0, b}, 32'h0000_00FF);
        do_tick(1);
        rd_reg(4'd1, b);
        check("R5 snapshot byte1", {24'b0, b}, 32'd0);
        rd_reg(4'd0, b);
        check("R5 relatch lsb", {24'b0, b}, 32'd0);
        rd_reg(4'd1, b);
        check("R5 carried byte1", {24'b0, b}, 32'd1);
        for (int a = 4; a < 8; a++) begin
            rd_reg(4'(a), b);
            check("R7 period read", {24'b0, b}, 32'h0000_00FF);
        end

        // R8 busy window
        set_period(32'd10);
        rd_reg(4'd8, b);
        check("R8 busy flag", {24'b0, b}, 32'd2);
        rd_reg(4'd0, b);
        check("R8 ignored read", {24'b0, b}, 32'd2);
        wr_reg(4'd4, 8'h55);
        rd_reg(4'd4, b);
        check("R8 ignored commit", {24'b0, b}, 32'd10);
        do_tick(1);
        rd_reg(4'd8, b);
        check("R8 busy cleared", {24'b0, b}, 32'd0);
        rd_cnt(v);
        check("R8 count after guard", v, 32'd1);

        // R6 staged period write
        do_tick(4);
        wr_reg(4'd7, 8'h00);
        wr_reg(4'd6, 8'h00);
        wr_reg(4'd5, 8'h01);
        rd_reg(4'd5, b);
        check("R6 staged not active", {24'b0, b}, 32'd0);
        rd_cnt(v);
        check("R6 count before commit", v, 32'd5);
        wr_reg(4'd7, 8'h00);
        wr_reg(4'd6, 8'h00);
        wr_reg(4'd5, 8'h01);
        wr_reg(4'd4, 8'h20);
        rd_reg(4'd4, b);
        check("R6 committed lsb", {24'b0, b}, 32'h20);
        rd_reg(4'd5, b);
        check("R6 committed byte1", {24'b0, b}, 32'h01);
        do_tick(1);
        rd_cnt(v);
        check("R6 restart", v, 32'd1);

        // R4 sticky interrupt
        wr_reg(4'd8, 8'h01);
        set_period(32'd3);
        do_tick(3);
        check("R4 set", {31'b0, irq}, 32'd1);
        wr_reg(4'd8, 8'h00);
        check("R4 write zero", {31'b0, irq}, 32'd1);
        do_tick(1);
        rd_cnt(v);
        check("R4 keeps counting", v, 32'd1);
        wr_reg(4'd8, 8'h01);
        check("R4 clear", {31'b0, irq}, 32'd0);
        do_tick(1);
        @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 4'd8; wdata = 8'h01;
        @(negedge clk); tick = 1'b0; wr = 1'b0;
        check("R4 set beats clear", {31'b0, irq}, 32'd1);

        // R10 warm reset
        @(negedge clk); warm_n = 1'b0;
        @(negedge clk); warm_n = 1'b1;
        check("R10 irq cleared", {31'b0, irq}, 32'd0);
        rd_reg(4'd8, b);
        check("R10 status", {24'b0, b}, 32'd0);
        rd_reg(4'd4, b);
        check("R10 period kept", {24'b0, b}, 32'd3);
        rd_cnt(v);
        check("R10 count cleared", v, 32'd0);
        do_tick(2);
        rd_cnt(v);
        check("R10 resumes", v, 32'd2);

        // R11 zero period
        set_period(32'd0);
        do_tick(5);
        rd_cnt(v);
        check("R11 stopped", v, 32'd0);
        check("R11 no irq", {31'b0, irq}, 32'd0);

        // R10 power-on reset clears period
        set_period(32'd7);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd_reg(4'd4, b);
        check("R10 por period", {24'b0, b}, 32'd0);
        do_tick(3);
        rd_cnt(v);
        check("R1 disabled after por", v, 32'd0);

        summary();
    end
endmodule